// File: doc/BRIEF.md
# Glitch-Free Clock Output Gating Controller

This block decides, for every clock output of a system clock generator, whether that output toggles or is held low. Each output group has its own running source clock: CPU, SDRAM, PCI, IOAPIC, 66 MHz hub, reference and 48 MHz. The block sees each source as a level on its input and samples it with a faster system clock. Every output is a registered copy of its group's source, gated by a per-lane "open" flag. That flag is only ever updated while the source is low. As a result, an output can only stop or start at a point where it is already low, and every high pulse it does produce has full width.

A lane is open when its configuration enable is set and the block is not powered down. The power-down request is an active-low asynchronous pin. It passes through a two-flop synchroniser. It then counts as a request only after it is seen low at two consecutive rising edges of the CPU source clock. Release is taken at the first CPU rising edge that sees the synchronised pin high. Three configuration bytes select which lanes are enabled. The free-running SDRAM lane and a fixed set of always-on lanes ignore those bytes.

Top module: `clkgate_ctl`

## Requirements
- R1: `pd_status` goes to 1 only after the synchronised `pd_n` has been sampled low at two consecutive rising edges of `cpu_ck`. A low pulse on `pd_n` that covers at most one such edge leaves `pd_status` at 0.
- R2: Once power-down is in effect, each output finishes its current high pulse and goes low at its own next falling edge. It never emits a shortened pulse.
- R3: While `pd_status` is 1 and every lane has passed a low phase, all outputs, `sdram_free_q` included, stay at 0.
- R4: An enabled lane reproduces its source clock one system-clock cycle later. A lane whose enable is 0 is held at 0.
- R5: `cfg_sdram_en[i]` enables `sdram_q[i]` for i = 0..7.
- R6: `cfg_pci_en[i]` enables `pci_q[i]` for i = 1..7. `pci_q[0]` is always enabled, and `cfg_pci_en[0]` has no effect.
- R7: `cfg_ctl[2]` enables `usb_q[1]`, `cfg_ctl[1]` enables `usb_q[0]` and `cfg_ctl[0]` enables `cpu_q[2]`. `cpu_q[1:0]`, `apic_q`, `hub_q` and `ref_q` are always enabled. `cfg_ctl[7:3]` has no effect.
- R8: `sdram_free_q` follows `sdram_ck` whatever the configuration bytes hold.
- R9: A change of an enable bit changes the lane's gating only while its source is low. Every high pulse on any output therefore lasts exactly the source's high time.
- R10: `pd_status` returns to 0 at the first `cpu_ck` rising edge that sees the synchronised `pd_n` high. Outputs then resume with full pulses.
- R11: While `rst` is high, every output and `pd_status` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cfg_ctl | input | 8 | Bit 2: usb_q[1], bit 1: usb_q[0], bit 0: cpu_q[2] enables |
| cfg_sdram_en | input | 8 | SDRAM lane enables |
| cfg_pci_en | input | 8 | PCI lane enables, bits 7..1 |
| cpu_ck | input | 1 | CPU group source clock |
| sdram_ck | input | 1 | SDRAM group source clock |
| pci_ck | input | 1 | PCI group source clock |
| apic_ck | input | 1 | IOAPIC group source clock |
| hub_ck | input | 1 | 66 MHz hub group source clock |
| ref_ck | input | 1 | Reference group source clock |
| usb_ck | input | 1 | 48 MHz group source clock |
| cpu_q | output | 3 | Gated CPU clocks |
| sdram_q | output | 8 | Gated SDRAM clocks |
| sdram_free_q | output | 1 | Free-running SDRAM clock |
| pci_q | output | 8 | Gated PCI clocks |
| apic_q | output | 2 | Gated IOAPIC clocks |
| hub_q | output | 2 | Gated hub clocks |
| ref_q | output | 1 | Gated reference clock |
| usb_q | output | 2 | Gated 48 MHz clocks |
| pd_status | output | 1 | Power-down in effect |

## Verification
On every cycle, the assertions check three things. A lane's open flag only moves after a low source sample. A stopped or disabled lane goes low once its source is low. Power-down is entered and left only at CPU rising edges, with the required low-sample history. The bench scenarios cover the rest, which no single-cycle property can show. They confirm the mapping from each configuration bit to its lane and the behaviour of the always-on and free-running lanes. They also check that a short power-down glitch is ignored, that all outputs go silent after entry and resume after release, and that every pulse keeps full width while enables toggle at random.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  parameter int CFG_W = 8;
  parameter int SYNC_STAGES = 2;
endpackage

// File: rtl/clkgate_pd_seq.sv
module clkgate_pd_seq
  import clkgate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  input  logic cpu_ck,
  output logic pd_on
);
  logic [SYNC_STAGES-1:0] sync;
  logic cpu_d;
  logic low_seen;
  logic rise;
  logic pd_req_n;

  assign rise     = cpu_ck & ~cpu_d;
  assign pd_req_n = sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= '1;
      cpu_d    <= 1'b0;
      low_seen <= 1'b0;
      pd_on    <= 1'b0;
    end else begin
      sync  <= {sync[SYNC_STAGES-2:0], pd_n};
      cpu_d <= cpu_ck;
      if (rise) begin
        if (!pd_req_n) begin
          low_seen <= 1'b1;
          if (low_seen) pd_on <= 1'b1;
        end else begin
          low_seen <= 1'b0;
          pd_on    <= 1'b0;
        end
      end
    end
  end

  // R1: entry needs a previous low sample plus a low sample at this CPU rise
  a_r1_two_samples: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_on) |-> ($past(low_seen) && $past(rise) && !$past(pd_req_n)));

  // R10: release happens only at a CPU rise that sees the request gone
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_on) |-> ($past(pd_req_n) && $past(rise)));
endmodule

// File: rtl/clkgate_bank.sv
module clkgate_bank #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ck,
  input  logic         stop,
  input  logic [N-1:0] en,
  output logic [N-1:0] q
);
  logic [N-1:0] open;

  always_ff @(posedge clk) begin
    if (rst) begin
      open <= '0;
      q    <= '0;
    end else begin
      if (!ck) open <= en & {N{~stop}};
      q <= {N{ck}} & open;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lane
    // R9: gating decision changes only after a low source sample
    a_r9_switch_low: assert property (@(posedge clk) disable iff (rst)
      !$stable(open[i]) |-> !$past(ck));
    // R2: a stopped lane is low once its source has been low
    a_r2_stop_low: assert property (@(posedge clk) disable iff (rst)
      (stop && !ck) |=> !q[i]);
    // R4: a disabled lane is low once its source has been low
    a_r4_off_low: assert property (@(posedge clk) disable iff (rst)
      (!en[i] && !ck) |=> !q[i]);
  end
endmodule

// File: rtl/clkgate_ctl.sv
module clkgate_ctl
  import clkgate_pkg::*;
#(
  parameter int N_CPU   = 3,
  parameter int N_SDRAM = 8,
  parameter int N_PCI   = 8,
  parameter int N_APIC  = 2,
  parameter int N_HUB   = 2,
  parameter int N_USB   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd_n,
  input  logic [CFG_W-1:0]   cfg_ctl,
  input  logic [CFG_W-1:0]   cfg_sdram_en,
  input  logic [CFG_W-1:0]   cfg_pci_en,
  input  logic               cpu_ck,
  input  logic               sdram_ck,
  input  logic               pci_ck,
  input  logic               apic_ck,
  input  logic               hub_ck,
  input  logic               ref_ck,
  input  logic               usb_ck,
  output logic [N_CPU-1:0]   cpu_q,
  output logic [N_SDRAM-1:0] sdram_q,
  output logic               sdram_free_q,
  output logic [N_PCI-1:0]   pci_q,
  output logic [N_APIC-1:0]  apic_q,
  output logic [N_HUB-1:0]   hub_q,
  output logic               ref_q,
  output logic [N_USB-1:0]   usb_q,
  output logic               pd_status
);
  logic stop;
  logic [N_CPU-1:0]   cpu_en;
  logic [N_PCI-1:0]   pci_en;
  logic [N_USB-1:0]   usb_en;
  logic unused_cfg;

  assign cpu_en = {cfg_ctl[0], {(N_CPU-1){1'b1}}};
  assign pci_en = {cfg_pci_en[N_PCI-1:1], 1'b1};
  assign usb_en = cfg_ctl[N_USB:1];
  assign unused_cfg = ^{cfg_ctl, cfg_pci_en};

  clkgate_pd_seq u_pd (
    .clk(clk), .rst(rst), .pd_n(pd_n), .cpu_ck(cpu_ck), .pd_on(stop)
  );
  assign pd_status = stop;

  clkgate_bank #(.N(N_CPU)) u_cpu (
    .clk(clk), .rst(rst), .ck(cpu_ck), .stop(stop), .en(cpu_en), .q(cpu_q));
  clkgate_bank #(.N(N_SDRAM)) u_sdram (
    .clk(clk), .rst(rst), .ck(sdram_ck), .stop(stop),
    .en(cfg_sdram_en[N_SDRAM-1:0]), .q(sdram_q));
  clkgate_bank #(.N(1)) u_sdram_free (
    .clk(clk), .rst(rst), .ck(sdram_ck), .stop(stop), .en(1'b1), .q(sdram_free_q));
  clkgate_bank #(.N(N_PCI)) u_pci (
    .clk(clk), .rst(rst), .ck(pci_ck), .stop(stop), .en(pci_en), .q(pci_q));
  clkgate_bank #(.N(N_APIC)) u_apic (
    .clk(clk), .rst(rst), .ck(apic_ck), .stop(stop), .en({N_APIC{1'b1}}), .q(apic_q));
  clkgate_bank #(.N(N_HUB)) u_hub (
    .clk(clk), .rst(rst), .ck(hub_ck), .stop(stop), .en({N_HUB{1'b1}}), .q(hub_q));
  clkgate_bank #(.N(1)) u_ref (
    .clk(clk), .rst(rst), .ck(ref_ck), .stop(stop), .en(1'b1), .q(ref_q));
  clkgate_bank #(.N(N_USB)) u_usb (
    .clk(clk), .rst(rst), .ck(usb_ck), .stop(stop), .en(usb_en), .q(usb_q));

  // R8: the free-running lane only drops out of a high phase at a source low
  a_r8_free_full: assert property (@(posedge clk) disable iff (rst)
    ($past(sdram_free_q) && !sdram_free_q) |-> !$past(sdram_ck));
endmodule

// File: tb/sim_clkgate_ctl.sv
module sim_clkgate_ctl;
  logic clk = 1'b0, rst = 1'b1, pd_n = 1'b1;
  logic [7:0] cfg_ctl = 8'hFF, cfg_sdram_en = 8'hFF, cfg_pci_en = 8'hFF;
  logic cpu_ck = 0, sdram_ck = 0, pci_ck = 0, apic_ck = 0, hub_ck = 0, ref_ck = 0, usb_ck = 0;
  logic [2:0] cpu_q; logic [7:0] sdram_q; logic sdram_free_q; logic [7:0] pci_q;
  logic [1:0] apic_q, hub_q, usb_q; logic ref_q, pd_status;

  clkgate_ctl u0 (.*);

  always #4 clk = ~clk;

  int n_checks = 0, n_err = 0;
  bit finished = 0, steady = 0, quiet = 0;
  logic [26:0] q_all, src_all, src_smp = '0, en_exp = '1, prev_q = '0;
  int run_len [27];
  int unsigned tc = 0;

  assign q_all = {usb_q, ref_q, hub_q, apic_q, pci_q, sdram_free_q, sdram_q, cpu_q};
  assign src_all = {{2{usb_ck}}, ref_ck, {2{hub_ck}}, {2{apic_ck}}, {8{pci_ck}},
                    sdram_ck, {8{sdram_ck}}, {3{cpu_ck}}};

  function automatic logic [26:0] exp_en(input logic [7:0] c0, c1, c2);
    return {c0[2], c0[1], 1'b1, 2'b11, 2'b11, c2[7:1], 1'b1, 1'b1, c1, c0[0], 2'b11};
  endfunction

  function automatic string req_of(input int b);
    if (b < 2) return "R7 cpu";
    if (b == 2) return "R7 cpu2";
    if (b < 11) return "R5 sdram";
    if (b == 11) return "R8 free";
    if (b < 20) return "R6 pci";
    return "R7 fixed/usb";
  endfunction

  function automatic int hi_of(input int b);
    if (b < 3) return 2;
    if (b < 12) return 3;
    if (b < 22) return 4;
    if (b < 24) return 3;
    if (b == 24) return 5;
    return 7;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // source clock generator, driven away from the sampling edge
  always @(posedge clk) begin
    #1;
    src_smp = src_all;
    tc++;
    cpu_ck   = (tc % 4) < 2;
    sdram_ck = (tc % 6) < 3;
    pci_ck   = (tc % 8) < 4;
    apic_ck  = ((tc + 3) % 8) < 4;
    hub_ck   = ((tc + 1) % 6) < 3;
    ref_ck   = (tc % 10) < 5;
    usb_ck   = (tc % 14) < 7;
  end

  // monitor: pulse widths (R2, R9), steady mapping (R4..R8), silence (R3)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int b = 0; b < 27; b++) begin
        if (q_all[b]) run_len[b]++;
        else begin
          if (prev_q[b]) chk(run_len[b] == hi_of(b), $sformatf("R2/R9 pulse width lane %0d", b),
                             run_len[b], hi_of(b));
          run_len[b] = 0;
        end
      end
      prev_q = q_all;
      if (steady) begin
        logic [26:0] e;
        int fb;
        e = src_smp & en_exp;
        fb = 0;
        for (int b = 26; b >= 0; b--) if (q_all[b] != e[b]) fb = b;
        chk(q_all == e, $sformatf("R4 %s lane %0d", req_of(fb), fb), q_all, e);
      end
      if (quiet) chk(q_all == '0, "R3 all outputs low in power-down", q_all, 0);
    end
  end

  task automatic set_cfg(input logic [7:0] c0, c1, c2, input int hold);
    @(posedge clk); #1;
    steady = 0;
    cfg_ctl = c0; cfg_sdram_en = c1; cfg_pci_en = c2;
    en_exp = exp_en(c0, c1, c2);
    repeat (16) @(posedge clk);
    #1 steady = 1;
    repeat (hold) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < 27; b++) run_len[b] = 0;
    repeat (3) @(negedge clk);
    chk(q_all == '0, "R11 outputs in reset", q_all, 0);
    chk(pd_status == 1'b0, "R11 pd_status in reset", pd_status, 0);
    @(posedge clk); #1 rst = 0;

    // directed enable patterns
    set_cfg(8'hFF, 8'hFF, 8'hFF, 40);
    set_cfg(8'h00, 8'h00, 8'h00, 40);            // R8 free lane still runs
    set_cfg(8'hF8, 8'h00, 8'h01, 40);            // R7 upper bits, R6 bit 0 ignored
    set_cfg(8'h01, 8'hA5, 8'h5A, 40);            // R5 R6 R7 mixed
    set_cfg(8'h04, 8'h80, 8'h80, 40);
    set_cfg(8'h02, 8'h01, 8'h02, 40);
    for (int k = 0; k < 20; k++)
      set_cfg(8'($urandom), 8'($urandom), 8'($urandom), 30 + ($urandom % 30));

    // rapid enable toggling: only pulse-width checking (R9)
    @(posedge clk); #1 steady = 0;
    for (int k = 0; k < 80; k++) begin
      cfg_ctl = 8'($urandom); cfg_sdram_en = 8'($urandom); cfg_pci_en = 8'($urandom);
      repeat (1 + ($urandom % 4)) @(posedge clk);
      #1;
    end
    set_cfg(8'hFF, 8'hFF, 8'hFF, 40);

    // R1: short glitch covering at most one CPU rise is ignored
    @(posedge clk); #1 pd_n = 0;
    repeat (2) @(posedge clk);
    #1 pd_n = 1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(pd_status == 1'b0, "R1 glitch ignored", pd_status, 0);
    end

    // R1: sustained request; no entry before two CPU rises
    @(posedge clk); #1 pd_n = 0; steady = 0;
    repeat (4) @(negedge clk);
    chk(pd_status == 1'b0, "R1 not yet after one rise", pd_status, 0);
    repeat (10) @(negedge clk);
    chk(pd_status == 1'b1, "R1 entered after two rises", pd_status, 1);
    repeat (16) @(negedge clk);
    quiet = 1;
    repeat (40) @(negedge clk);
    chk(pd_status == 1'b1, "R3 stays powered down", pd_status, 1);

    // R10: release
    @(posedge clk); #1 pd_n = 1; quiet = 0;
    @(negedge clk);
    chk(pd_status == 1'b1, "R10 release not immediate", pd_status, 1);
    repeat (13) @(negedge clk);
    chk(pd_status == 1'b0, "R10 released", pd_status, 0);
    repeat (16) @(posedge clk);
    #1 steady = 1;
    repeat (60) @(posedge clk);

    // second power-down cycle with a sparse configuration
    set_cfg(8'h02, 8'h11, 8'h40, 20);
    @(posedge clk); #1 pd_n = 0; steady = 0;
    repeat (30) @(negedge clk);
    quiet = 1;
    repeat (30) @(negedge clk);
    @(posedge clk); #1 pd_n = 1; quiet = 0;
    repeat (30) @(posedge clk);
    #1 steady = 1;
    repeat (60) @(posedge clk);

    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule